// File: doc/BRIEF.md
# Extended-Identifier Acceptance Filter Scanner

This block decides what happens to a received CAN frame that carries a 29-bit identifier. A list of filter elements sits in a word-addressed RAM, each element taking two consecutive 32-bit words. After a start pulse the block walks the list one element at a time through a single read port. It passes over switched-off elements and stops at the first enabled element whose condition holds. The result is a done pulse with a hit flag, the index of the element that matched and an action code. When nothing matches before the configured list length runs out, a selectable default action is reported instead.

An element is either an ordinary filter or a special element. An ordinary filter chooses FIFO 0, FIFO 1, rejection or a priority marking, and compares the identifier by inclusive range, by two exact values or by value under a mask. A global 29-bit mask is ANDed into the identifier first, and one range variant skips that mask. A special element compares the masked identifier exactly with its first ID. It steers the frame to an indexed receive buffer or to one of three debug-message slots, and it can pulse up to three event outputs for one clock.

Top module: `xidf_scan`

## Requirements
- R1: Element n is read at list_base_i + 2n (word 0, holding the configuration in bits 31:29 and ID1 in bits 28:0) and then at list_base_i + 2n + 1 (word 1, holding the type in bits 31:30 and ID2 in bits 28:0). Read data is valid one cycle after mem_rd_o, and mem_rd_o is only asserted while busy_o is high.
- R2: An element whose configuration is 0 never matches, and its word 1 is not read.
- R3: The scan ends at the lowest-indexed enabled element that matches. done_o is then high for exactly one cycle, with hit_o = 1 and hit_idx_o = that index, and busy_o is low in the cycle in which done_o is high.
- R4: If no element below list_len_i matches, done_o comes with hit_o = 0 and hit_idx_o = 0. action_o is then 2 (reject) when dflt_reject_i = 1 and 0 (FIFO 0) when dflt_reject_i = 0. A list length of 0 raises done_o in the cycle after the start edge and makes no read.
- R5: Action codes for a hit: configuration 1 gives 0 (FIFO 0), 2 gives 1 (FIFO 1), 3 gives 2 (reject), 4 gives 7 (priority only), 5 gives 0, 6 gives 1.
- R6: Type 0 matches when ID1 <= masked ID <= ID2. Type 3 applies the same inclusive bounds to the unmasked ID.
- R7: Type 1 matches when the masked ID equals ID1 or ID2. Type 2 matches when (masked ID & ID2) equals (ID1 & ID2).
- R8: The masked ID is rx_id_i AND gmask_i. It is used for types 0, 1 and 2 and for configuration 7.
- R9: A hit on configuration 4, 5 or 6 raises prio_o together with done_o. prio_idx_o takes that index and holds it until the next such hit.
- R10: Configuration 7 ignores the type field and matches only when the masked ID equals ID1. ID2 bits 10:9 select the action: 00 gives 3 (Rx buffer), 01 gives 4, 10 gives 5, 11 gives 6 (debug A, B, C). buf_addr_o = rxbuf_base_i + ID2[5:0]. On every other outcome buf_addr_o is 0.
- R11: On a configuration-7 hit, evt_o[k] is high for exactly the done cycle when ID2 bit 6+k is set. Otherwise evt_o is 0.
- R12: A start pulse while busy_o is high is ignored. The running scan finishes with its own identifier and produces a single done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a scan (taken only when idle) |
| rx_id_i | input | 29 | Received extended identifier |
| gmask_i | input | 29 | Global identifier mask |
| list_base_i | input | AW | Word address of element 0 |
| list_len_i | input | 7 | Number of elements to scan (0 to 64) |
| rxbuf_base_i | input | AW | Receive buffer base address |
| dflt_reject_i | input | 1 | Default action on no match: 1 reject, 0 FIFO 0 |
| mem_rd_o | output | 1 | RAM read strobe |
| mem_addr_o | output | AW | RAM word address |
| mem_rdata_i | input | 32 | RAM read data, one cycle after the strobe |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hit_o | output | 1 | An element matched |
| hit_idx_o | output | 6 | Index of the matching element |
| action_o | output | 3 | Action code |
| prio_o | output | 1 | High-priority match pulse |
| prio_idx_o | output | 6 | Index of the last priority match |
| buf_addr_o | output | AW | Rx buffer storage address |
| evt_o | output | 3 | One-cycle filter event pulses |

## Verification
Every element type gets identifiers just inside and just outside its bounds. Inclusive range edges are told apart from off-by-one comparisons, and a dual-ID miss is told apart from a partial match. One identifier hits both an early dual element and a later range element, which separates first-match from last-match. Another matches a disabled element only, which shows that disabled entries are skipped. The special element gets an identifier that its ignored classic type would accept but the exact compare must refuse. Changing the global mask shows that masked types see the ANDed identifier while the unmasked range sees the raw one. A scan with a shortened list length, a length of zero and a start pulse during a scan cover the termination rules.

// File: rtl/xidf_pkg.sv
package xidf_pkg;
  localparam int unsigned XID_W  = 29;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned EVT_W  = 3;
  localparam int unsigned OFS_W  = 6;

  typedef enum logic [2:0] {
    CFG_OFF, CFG_FIFO0, CFG_FIFO1, CFG_REJECT,
    CFG_PRIO, CFG_PRIO_F0, CFG_PRIO_F1, CFG_SPECIAL
  } cfg_e;

  typedef enum logic [1:0] {
    TY_RANGE_M, TY_DUAL, TY_CLASSIC, TY_RANGE_RAW
  } type_e;

  typedef enum logic [2:0] {
    ACT_FIFO0, ACT_FIFO1, ACT_REJECT, ACT_RXBUF,
    ACT_DBG_A, ACT_DBG_B, ACT_DBG_C, ACT_PRIO_ONLY
  } act_e;

  typedef enum logic [1:0] {S_IDLE, S_W0, S_W1, S_EVAL} st_e;
endpackage

// File: rtl/xidf_elem_match.sv
module xidf_elem_match
  import xidf_pkg::*;
(
  input  logic [XID_W-1:0]  rx_id,
  input  logic [XID_W-1:0]  gmask,
  input  logic [WORD_W-1:0] word0,
  input  logic [WORD_W-1:0] word1,
  output logic              hit
);
  cfg_e              cfg;
  type_e             ty;
  logic [XID_W-1:0]  mid, id1, id2;

  always_comb begin
    cfg = cfg_e'(word0[31:29]);
    ty  = type_e'(word1[31:30]);
    id1 = word0[XID_W-1:0];
    id2 = word1[XID_W-1:0];
    mid = rx_id & gmask;
    hit = 1'b0;
    if (cfg == CFG_SPECIAL) begin
      hit = (mid == id1);
    end else if (cfg != CFG_OFF) begin
      case (ty)
        TY_RANGE_M:   hit = (mid >= id1) && (mid <= id2);
        TY_DUAL:      hit = (mid == id1) || (mid == id2);
        TY_CLASSIC:   hit = ((mid & id2) == (id1 & id2));
        TY_RANGE_RAW: hit = (rx_id >= id1) && (rx_id <= id2);
        default:      hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/xidf_action_dec.sv
module xidf_action_dec
  import xidf_pkg::*;
(
  input  logic [WORD_W-1:0] word0,
  input  logic [WORD_W-1:0] word1,
  output act_e              act,
  output logic              prio,
  output logic              special,
  output logic [EVT_W-1:0]  evt_en,
  output logic [OFS_W-1:0]  ofs
);
  cfg_e cfg;

  always_comb begin
    cfg     = cfg_e'(word0[31:29]);
    prio    = 1'b0;
    special = 1'b0;
    evt_en  = word1[6 +: EVT_W];
    ofs     = word1[OFS_W-1:0];
    case (cfg)
      CFG_FIFO0:   act = ACT_FIFO0;
      CFG_FIFO1:   act = ACT_FIFO1;
      CFG_REJECT:  act = ACT_REJECT;
      CFG_PRIO:    begin act = ACT_PRIO_ONLY; prio = 1'b1; end
      CFG_PRIO_F0: begin act = ACT_FIFO0;     prio = 1'b1; end
      CFG_PRIO_F1: begin act = ACT_FIFO1;     prio = 1'b1; end
      CFG_SPECIAL: begin
        special = 1'b1;
        case (word1[10:9])
          2'b00:   act = ACT_RXBUF;
          2'b01:   act = ACT_DBG_A;
          2'b10:   act = ACT_DBG_B;
          default: act = ACT_DBG_C;
        endcase
      end
      default:     act = ACT_FIFO0;
    endcase
  end
endmodule

// File: rtl/xidf_scan.sv
module xidf_scan
  import xidf_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned MAX_ELEM = 64,
  localparam int unsigned IDX_W   = $clog2(MAX_ELEM),
  localparam int unsigned LEN_W   = $clog2(MAX_ELEM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [XID_W-1:0]  rx_id_i,
  input  logic [XID_W-1:0]  gmask_i,
  input  logic [AW-1:0]     list_base_i,
  input  logic [LEN_W-1:0]  list_len_i,
  input  logic [AW-1:0]     rxbuf_base_i,
  input  logic              dflt_reject_i,
  output logic              mem_rd_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic [2:0]        action_o,
  output logic              prio_o,
  output logic [IDX_W-1:0]  prio_idx_o,
  output logic [AW-1:0]     buf_addr_o,
  output logic [EVT_W-1:0]  evt_o
);
  st_e               state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] w0_q;
  logic [XID_W-1:0]  id_q, mask_q;
  logic              fin, fin_hit, last, accept;
  logic              elem_hit, dec_prio, dec_special;
  act_e              dec_act;
  logic [EVT_W-1:0]  dec_evt, evt_gate;
  logic [OFS_W-1:0]  dec_ofs;
  logic [AW-1:0]     elem_base;
  cfg_e              rd_cfg;

  logic              hit_q, done_q, prio_q;
  logic [IDX_W-1:0]  hidx_q, pidx_q;
  logic [2:0]        act_q;
  logic [AW-1:0]     baddr_q;
  logic [EVT_W-1:0]  evt_q;

  xidf_elem_match u_match (
    .rx_id (id_q), .gmask (mask_q), .word0 (w0_q), .word1 (mem_rdata_i),
    .hit   (elem_hit)
  );

  xidf_action_dec u_dec (
    .word0 (w0_q), .word1 (mem_rdata_i), .act (dec_act), .prio (dec_prio),
    .special (dec_special), .evt_en (dec_evt), .ofs (dec_ofs)
  );

  for (genvar g = 0; g < EVT_W; g++) begin : g_evt
    assign evt_gate[g] = fin_hit & dec_special & dec_evt[g];
  end

  assign rd_cfg    = cfg_e'(mem_rdata_i[31:29]);
  assign last      = (LEN_W'(idx_q) + LEN_W'(1)) == list_len_i;
  assign accept    = (state_q == S_IDLE) && start_i;
  assign elem_base = list_base_i + (AW'(idx_q) << 1);
  assign mem_rd_o  = (state_q == S_W0) || ((state_q == S_W1) && (rd_cfg != CFG_OFF));
  assign mem_addr_o = elem_base + ((state_q == S_W1) ? AW'(1) : AW'(0));

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    fin     = 1'b0;
    fin_hit = 1'b0;
    case (state_q)
      S_IDLE: if (start_i) begin
        if (list_len_i == '0) fin = 1'b1;
        else begin state_d = S_W0; idx_d = '0; end
      end
      S_W0: state_d = S_W1;
      S_W1: begin
        if (rd_cfg != CFG_OFF) state_d = S_EVAL;
        else if (last) begin fin = 1'b1; state_d = S_IDLE; end
        else begin idx_d = idx_q + 1'b1; state_d = S_W0; end
      end
      S_EVAL: begin
        if (elem_hit) begin fin = 1'b1; fin_hit = 1'b1; state_d = S_IDLE; end
        else if (last) begin fin = 1'b1; state_d = S_IDLE; end
        else begin idx_d = idx_q + 1'b1; state_d = S_W0; end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      w0_q    <= '0;
      id_q    <= '0;
      mask_q  <= '0;
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
      hidx_q  <= '0;
      act_q   <= '0;
      prio_q  <= 1'b0;
      pidx_q  <= '0;
      baddr_q <= '0;
      evt_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= fin;
      prio_q  <= fin_hit & dec_prio;
      evt_q   <= evt_gate;
      if (state_q == S_W1) w0_q <= mem_rdata_i;
      if (accept) begin
        id_q   <= rx_id_i;
        mask_q <= gmask_i;
      end
      if (fin) begin
        hit_q   <= fin_hit;
        hidx_q  <= fin_hit ? idx_q : '0;
        act_q   <= fin_hit ? dec_act : (dflt_reject_i ? ACT_REJECT : ACT_FIFO0);
        baddr_q <= (fin_hit && dec_special) ? rxbuf_base_i + AW'(dec_ofs) : '0;
      end
      if (fin_hit && dec_prio) pidx_q <= idx_q;
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign hit_o      = hit_q;
  assign hit_idx_o  = hidx_q;
  assign action_o   = act_q;
  assign prio_o     = prio_q;
  assign prio_idx_o = pidx_q;
  assign buf_addr_o = baddr_q;
  assign evt_o      = evt_q;
endmodule

// File: rtl/xidf_scan_chk.sv
module xidf_scan_chk #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned LEN_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [LEN_W-1:0] list_len_i,
  input logic             mem_rd_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             hit_o,
  input logic [IDX_W-1:0] hit_idx_o,
  input logic [2:0]       action_o,
  input logic             prio_o,
  input logic [2:0]       evt_o
);
  assert_read_only_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> busy_o);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_hit_in_list_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && hit_o) |-> (hit_idx_o < list_len_i));

  assert_len_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && list_len_i == '0) |=> (done_o && !hit_o && !mem_rd_o));

  assert_prio_on_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prio_o |-> (done_o && hit_o));

  assert_evt_special_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o != 3'b000) |-> (done_o && hit_o && action_o >= 3'd3 && action_o <= 3'd6));
endmodule

bind xidf_scan xidf_scan_chk #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .start_i (start_i), .list_len_i (list_len_i),
  .mem_rd_o (mem_rd_o), .busy_o (busy_o), .done_o (done_o), .hit_o (hit_o),
  .hit_idx_o (hit_idx_o), .action_o (action_o), .prio_o (prio_o), .evt_o (evt_o)
);

// File: tb/xidf_scan_bench.sv
module xidf_scan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  typedef struct packed {
    logic [28:0] id;
    logic        hit;
    logic [5:0]  idx;
    logic [2:0]  act;
    logic        prio;
    logic [2:0]  evt;
    logic [15:0] baddr;
  } vec_t;

  // list: e0 off, e1 dual, e2 range, e3 classic, e4 raw range prio+F0,
  // e5 special dbg B, e6 special rxbuf, e7 range prio+F1, e8 prio-only dual
  localparam vec_t VECS [NV] = '{
    '{29'h100,      1'b1, 6'd1, 3'd0, 1'b0, 3'd0, 16'h0},    // R7 dual, R3 first match
    '{29'h200,      1'b1, 6'd1, 3'd0, 1'b0, 3'd0, 16'h0},    // R7 dual second id
    '{29'h1800,     1'b1, 6'd2, 3'd2, 1'b0, 3'd0, 16'h0},    // R6 R5 reject
    '{29'h1FFF,     1'b1, 6'd2, 3'd2, 1'b0, 3'd0, 16'h0},    // R6 upper bound
    '{29'h0AB1234,  1'b1, 6'd3, 3'd1, 1'b0, 3'd0, 16'h0},    // R7 classic
    '{29'h1F000001, 1'b1, 6'd4, 3'd0, 1'b1, 3'd0, 16'h0},    // R6 raw, R9
    '{29'h12345,    1'b1, 6'd5, 3'd5, 1'b0, 3'b101, 16'h0411}, // R10 R11
    '{29'h3777,     1'b1, 6'd6, 3'd3, 1'b0, 3'b010, 16'h0403}, // R10 R11
    '{29'h55,       1'b1, 6'd7, 3'd1, 1'b1, 3'd0, 16'h0},    // R2 skip e0, R9
    '{29'h60,       1'b1, 6'd7, 3'd1, 1'b1, 3'd0, 16'h0},    // R6 upper edge
    '{29'h61,       1'b0, 6'd0, 3'd0, 1'b0, 3'd0, 16'h0},    // R6 just above
    '{29'hFF,       1'b0, 6'd0, 3'd0, 1'b0, 3'd0, 16'h0},    // R6 just below
    '{29'h2000,     1'b0, 6'd0, 3'd0, 1'b0, 3'd0, 16'h0},    // R4 miss
    '{29'h12347,    1'b0, 6'd0, 3'd0, 1'b0, 3'd0, 16'h0},    // R10 type ignored
    '{29'h8888,     1'b1, 6'd8, 3'd7, 1'b1, 3'd0, 16'h0}     // R5 prio only
  };

  logic        clk, rst_n, start_i, dflt_reject_i;
  logic [28:0] rx_id_i, gmask_i;
  logic [15:0] list_base_i, rxbuf_base_i, mem_addr_o, buf_addr_o;
  logic [6:0]  list_len_i;
  logic        mem_rd_o, busy_o, done_o, hit_o, prio_o;
  logic [31:0] mem_rdata_i;
  logic [5:0]  hit_idx_o, prio_idx_o;
  logic [2:0]  action_o, evt_o;

  logic [31:0] mem [256];
  logic [15:0] rlog [16];
  int          rcnt;
  int          checks, errors, cyc, wait_n;

  xidf_scan u_xidf_scan (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .rx_id_i (rx_id_i),
    .gmask_i (gmask_i), .list_base_i (list_base_i), .list_len_i (list_len_i),
    .rxbuf_base_i (rxbuf_base_i), .dflt_reject_i (dflt_reject_i),
    .mem_rd_o (mem_rd_o), .mem_addr_o (mem_addr_o), .mem_rdata_i (mem_rdata_i),
    .busy_o (busy_o), .done_o (done_o), .hit_o (hit_o), .hit_idx_o (hit_idx_o),
    .action_o (action_o), .prio_o (prio_o), .prio_idx_o (prio_idx_o),
    .buf_addr_o (buf_addr_o), .evt_o (evt_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_rd_o) begin
      mem_rdata_i <= mem[mem_addr_o[7:0]];
      rlog[rcnt % 16] <= mem_addr_o;
      rcnt <= rcnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] w0(input logic [2:0] cfg, input logic [28:0] id);
    return {cfg, id};
  endfunction
  function automatic logic [31:0] w1(input logic [1:0] ty, input logic [28:0] id);
    return {ty, 1'b0, id};
  endfunction

  task automatic put(input int n, input logic [31:0] a, input logic [31:0] b);
    mem[16 + 2*n]     = a;
    mem[16 + 2*n + 1] = b;
  endtask

  task automatic scan(input logic [28:0] id);
    @(negedge clk);
    rx_id_i = id;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_n = 0;
    while (!done_o && wait_n < 400) begin
      @(negedge clk);
      wait_n++;
    end
    if (!done_o) check("R3", "done timeout", 0, 1);
  endtask

  initial begin
    int r0;
    checks = 0; errors = 0; cyc = 0; rcnt = 0;
    mem_rdata_i = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 16; i++) rlog[i] = '0;
    put(0, w0(3'd0, 29'h55),       w1(2'd1, 29'h55));
    put(1, w0(3'd1, 29'h100),      w1(2'd1, 29'h200));
    put(2, w0(3'd3, 29'h100),      w1(2'd0, 29'h1FFF));
    put(3, w0(3'd2, 29'h0AB0000),  w1(2'd2, 29'h0FF0000));
    put(4, w0(3'd5, 29'h1F000000), w1(2'd3, 29'h1FFFFFFF));
    put(5, w0(3'd7, 29'h12345),    w1(2'd2, 29'h551));
    put(6, w0(3'd7, 29'h3777),     w1(2'd0, 29'h083));
    put(7, w0(3'd6, 29'h50),       w1(2'd0, 29'h60));
    put(8, w0(3'd4, 29'h9999),     w1(2'd1, 29'h8888));

    rst_n = 1'b0; start_i = 1'b0; rx_id_i = '0; gmask_i = 29'h1FFFFFFF;
    list_base_i = 16'h0010; list_len_i = 7'd9; rxbuf_base_i = 16'h0400;
    dflt_reject_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R3", "reset done_o", done_o, 0);
    check("R3", "reset busy_o", busy_o, 0);
    check("R1", "reset mem_rd_o", mem_rd_o, 0);
    check("R11", "reset evt_o", evt_o, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      scan(VECS[v].id);
      check("R3", $sformatf("v%0d hit", v), hit_o, VECS[v].hit);
      check("R3", $sformatf("v%0d idx", v), hit_idx_o, VECS[v].idx);
      check("R5", $sformatf("v%0d action", v), action_o, VECS[v].act);
      check("R9", $sformatf("v%0d prio", v), prio_o, VECS[v].prio);
      check("R11", $sformatf("v%0d evt", v), evt_o, VECS[v].evt);
      check("R10", $sformatf("v%0d buf_addr", v), buf_addr_o, VECS[v].baddr);
      if (VECS[v].prio) check("R9", $sformatf("v%0d prio_idx", v), prio_idx_o, VECS[v].idx);
      @(negedge clk);
      check("R11", $sformatf("v%0d evt after done", v), evt_o, 0);
      check("R3", $sformatf("v%0d done one cycle", v), done_o, 0);
    end

    // R1 R2: read addresses for a hit on e1 with e0 disabled
    r0 = rcnt;
    scan(29'h100);
    check("R2", "read count e0 off + e1", rcnt - r0, 3);
    check("R1", "first read e0 word0", rlog[r0 % 16], 16'h0010);
    check("R1", "e1 word0", rlog[(r0 + 1) % 16], 16'h0012);
    check("R1", "e1 word1", rlog[(r0 + 2) % 16], 16'h0013);

    // R9: priority index held over a non-priority hit
    check("R9", "prio_idx held", prio_idx_o, 8);
    check("R9", "no prio on e1", prio_o, 0);

    // R4: default reject
    dflt_reject_i = 1'b1;
    scan(29'h2000);
    check("R4", "miss hit_o", hit_o, 0);
    check("R4", "default reject", action_o, 2);
    dflt_reject_i = 1'b0;

    // R4: list length limits the scan
    list_len_i = 7'd3;
    scan(29'h55);
    check("R4", "short list miss", hit_o, 0);
    check("R4", "short list action", action_o, 0);

    // R4: zero length
    list_len_i = 7'd0;
    r0 = rcnt;
    scan(29'h100);
    check("R4", "len0 latency", wait_n, 0);
    check("R4", "len0 no reads", rcnt - r0, 0);
    check("R4", "len0 hit", hit_o, 0);
    list_len_i = 7'd9;

    // R8: global mask
    gmask_i = 29'h0FFFFFFF;
    scan(29'h10000100);
    check("R8", "masked dual idx", hit_idx_o, 1);
    check("R8", "masked dual hit", hit_o, 1);
    scan(29'h1F000010);
    check("R6", "raw range ignores mask", hit_idx_o, 4);
    check("R6", "raw range hit", hit_o, 1);
    scan(29'h10003777);
    check("R10", "masked special idx", hit_idx_o, 6);
    check("R10", "masked special act", action_o, 3);
    gmask_i = 29'h1FFFFFFF;

    // R12: start during a scan is ignored
    @(negedge clk);
    rx_id_i = 29'h55; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    rx_id_i = 29'h100; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_n = 0;
    while (!done_o && wait_n < 400) begin @(negedge clk); wait_n++; end
    check("R12", "busy start idx", hit_idx_o, 7);
    begin
      int extra = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (done_o) extra++;
      end
      check("R12", "no second done", extra, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule